// File: doc/BRIEF.md
# Custom-Opcode Multiply-Accumulate Execution Unit

This unit executes a small family of custom instructions that share one 64-bit accumulator. Each cycle it may receive one instruction word with an issue strobe and the two 32-bit source operand values already read from the register file. Instructions in the custom-0 major opcode space are decoded here. They can clear the accumulator, copy its lower or upper word to a destination register, or add a product of the two operands to it. The product can be signed or unsigned. The sum can be 32-bit, where the upper half ends up cleared, or full 64-bit, where it wraps.

All results are registered. The write-back triple (enable, register index, data) and the illegal-instruction flag appear on the cycle after the issue edge. The accumulator is updated at that same edge, so an instruction issued in the next cycle already sees the new value. Words outside custom-0 are not this unit's business and are ignored. Custom-0 words that match none of the defined forms raise the illegal flag and leave all state alone.

Top module: `cmac_exec`

## Requirements
- R1: After reset the accumulator is zero and `wb_en_o` and `illegal_o` are low.
- R2: An issued word with opcode bits [6:0] = 7'b0001011, bits [14:12] = 0, bits [31:25] = 0, bits [24:15] = 0 and bits [11:7] = 0 clears the accumulator. It produces no write-back.
- R3: With bits [14:12] = 0 and bits [24:15] = 0, bits [31:25] = 1 returns accumulator bits [31:0] and bits [31:25] = 2 returns bits [63:32]. The value appears on `wb_data_o`, with `wb_idx_o` = bits [11:7] and `wb_en_o` high, one cycle after issue. When bits [11:7] = 0 the instruction is legal but `wb_en_o` stays low.
- R4: Bits [14:12] = 1 with bits [31:25] = 0 replaces the accumulator with {32'h0, (low 32 bits of the unsigned product + accumulator[31:0]) mod 2^32}.
- R5: Bits [14:12] = 1 with bits [31:25] = 1 does the same using the two's-complement product. The low 32 bits of that product are added and the upper accumulator half becomes zero.
- R6: Bits [14:12] = 2 with bits [31:25] = 0 adds the full 64-bit unsigned product of the operands to the accumulator modulo 2^64.
- R7: Bits [14:12] = 2 with bits [31:25] = 1 adds the 64-bit product of the sign-extended operands to the accumulator modulo 2^64.
- R8: Any other issued custom-0 word sets `illegal_o` for one cycle after issue. The accumulator is left unchanged and there is no write-back. This covers bits [14:12] ≥ 3, an unlisted bits [31:25] value, and the clear form with nonzero bits [11:7].
- R9: Accumulate forms with nonzero bits [11:7] are illegal under R8. Accumulator-management forms (bits [14:12] = 0) with nonzero bits [24:15] are also illegal under R8.
- R10: Words with any other major opcode are ignored: no flag, no write-back, no accumulator change.
- R11: With `issue_i` low, nothing changes and both `wb_en_o` and `illegal_o` are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 32 | First source operand value |
| src_b_i | input | 32 | Second source operand value |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Write-back data |
| illegal_o | output | 1 | Illegal custom-0 encoding seen on the previous issue |

## Verification
Within a single cycle, the accumulator register can take a new value while the registered write-back of the previous read is still on the outputs. A read issued right after an accumulate must also return the already-updated value. Back-to-back streams provoke this: an accumulate directly followed by low and high reads, plus a long pseudo-random instruction stream with no idle gaps. A behavioural model in the bench tracks the accumulator as a 64-bit integer. It is compared with the outputs at every falling edge, so any off-by-one-cycle update shows up as a data mismatch.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  localparam logic [6:0] CUSTOM0_OPC = 7'b0001011;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CLR   = 3'd1,
    OP_RDLO  = 3'd2,
    OP_RDHI  = 3'd3,
    OP_MAC32 = 3'd4,
    OP_MAC64 = 3'd5,
    OP_BAD   = 3'd6
  } cmac_op_e;

  typedef struct packed {
    cmac_op_e   op;
    logic       sgn;
    logic [4:0] rd;
  } cmac_dec_t;

endpackage

// File: rtl/cmac_decode.sv
module cmac_decode
  import cmac_pkg::*;
(
  input  logic [31:0] insn_i,
  output cmac_dec_t   dec_o
);

  logic [6:0] opc;
  logic [2:0] grp;
  logic [6:0] sel;
  logic [4:0] rd;
  logic       mid_zero;

  assign opc      = insn_i[6:0];
  assign rd       = insn_i[11:7];
  assign grp      = insn_i[14:12];
  assign mid_zero = (insn_i[24:15] == '0);
  assign sel      = insn_i[31:25];

  always_comb begin
    dec_o.op  = OP_NONE;
    dec_o.sgn = 1'b0;
    dec_o.rd  = rd;
    if (opc == CUSTOM0_OPC) begin
      dec_o.op = OP_BAD;
      unique case (grp)
        3'd0: begin
          if (mid_zero) begin
            if (sel == 7'd0 && rd == '0) dec_o.op = OP_CLR;
            else if (sel == 7'd1)        dec_o.op = OP_RDLO;
            else if (sel == 7'd2)        dec_o.op = OP_RDHI;
          end
        end
        3'd1, 3'd2: begin
          if (rd == '0 && sel[6:1] == '0) begin
            dec_o.op  = (grp == 3'd1) ? OP_MAC32 : OP_MAC64;
            dec_o.sgn = sel[0];
          end
        end
        default: dec_o.op = OP_BAD;
      endcase
    end
  end

endmodule

// File: rtl/cmac_datapath.sv
module cmac_datapath
  import cmac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmac_op_e              op_i,
  input  logic                  sgn_i,
  input  logic [XLEN-1:0]       a_i,
  input  logic [XLEN-1:0]       b_i,
  input  logic [2*XLEN-1:0]     acc_i,
  output logic [2*XLEN-1:0]     acc_nxt_o
);

  localparam int ACC_W = 2 * XLEN;

  logic [ACC_W-1:0] a_ext;
  logic [ACC_W-1:0] b_ext;
  logic [ACC_W-1:0] prod;
  logic [XLEN-1:0]  sum_lo;
  logic [ACC_W-1:0] sum_full;

  // Extension picks signedness; the low ACC_W bits of the product are then exact.
  assign a_ext    = {{XLEN{sgn_i & a_i[XLEN-1]}}, a_i};
  assign b_ext    = {{XLEN{sgn_i & b_i[XLEN-1]}}, b_i};
  assign prod     = a_ext * b_ext;
  assign sum_lo   = prod[XLEN-1:0] + acc_i[XLEN-1:0];
  assign sum_full = prod + acc_i;

  always_comb begin
    unique case (op_i)
      OP_CLR:   acc_nxt_o = '0;
      OP_MAC32: acc_nxt_o = {{XLEN{1'b0}}, sum_lo};
      OP_MAC64: acc_nxt_o = sum_full;
      default:  acc_nxt_o = acc_i;
    endcase
  end

endmodule

// File: rtl/cmac_exec.sv
module cmac_exec
  import cmac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            illegal_o
);

  localparam int ACC_W = 2 * XLEN;

  cmac_dec_t        dec;
  logic [ACC_W-1:0] acc_q, acc_d, acc_calc;
  logic             acc_en;
  logic             wb_en_d, ill_d, data_en;
  logic [XLEN-1:0]  data_d;

  cmac_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  cmac_datapath #(.XLEN(XLEN)) u_dp (
    .op_i      (dec.op),
    .sgn_i     (dec.sgn),
    .a_i       (src_a_i),
    .b_i       (src_b_i),
    .acc_i     (acc_q),
    .acc_nxt_o (acc_calc)
  );

  always_comb begin
    acc_en  = issue_i && (dec.op == OP_CLR || dec.op == OP_MAC32 || dec.op == OP_MAC64);
    acc_d   = acc_calc;
    data_en = issue_i && (dec.op == OP_RDLO || dec.op == OP_RDHI) && (dec.rd != '0);
    wb_en_d = data_en;
    data_d  = (dec.op == OP_RDHI) ? acc_q[ACC_W-1:XLEN] : acc_q[XLEN-1:0];
    ill_d   = issue_i && (dec.op == OP_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      wb_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o   <= wb_en_d;
      illegal_o <= ill_d;
      if (acc_en) acc_q <= acc_d;
      if (data_en) begin
        wb_idx_o  <= dec.rd;
        wb_data_o <= data_d;
      end
    end
  end

  // R3: a write-back never targets register zero
  p_wb_nonzero_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_idx_o != '0));

  // R2: a clear leaves the whole accumulator at zero
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && dec.op == OP_CLR) |=> (acc_q == '0));

  // R4: 32-bit accumulate leaves the upper half at zero
  p_mac32_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && dec.op == OP_MAC32) |=> (acc_q[ACC_W-1:XLEN] == '0));

  // R8: an illegal encoding leaves the accumulator untouched
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(acc_q));

  // R8: illegal flag and write-back never coincide
  p_illegal_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && wb_en_o));

  // R10: foreign opcodes have no effect
  p_foreign_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && dec.op == OP_NONE) |=> (!wb_en_o && !illegal_o && $stable(acc_q)));

  // R11: idle cycles have no effect
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wb_en_o && !illegal_o && $stable(acc_q)));

endmodule

// File: tb/cmac_exec_tb_top.sv
module cmac_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] insn, opa, opb;
  logic        wb_en, illegal;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  longint unsigned m_acc;
  bit              e_en, e_ill;
  bit [4:0]        e_idx;
  bit [31:0]       e_data;

  always #4 clk = ~clk;

  cmac_exec dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .insn_i(insn),
    .src_a_i(opa), .src_b_i(opb), .wb_en_o(wb_en), .wb_idx_o(wb_idx),
    .wb_data_o(wb_data), .illegal_o(illegal)
  );

  function automatic bit [31:0] mk(input bit [6:0] f7, input bit [9:0] mid,
                                   input bit [2:0] f3, input bit [4:0] rd,
                                   input bit [6:0] opc = 7'b0001011);
    return {f7, mid, f3, rd, opc};
  endfunction

  task automatic model(input bit iss, input bit [31:0] w, input bit [31:0] a, input bit [31:0] b);
    longint sa, sb;
    longint unsigned ua, ub, p;
    bit [6:0] f7; bit [2:0] f3; bit [4:0] rd; bit [9:0] mid;
    f7 = w[31:25]; mid = w[24:15]; f3 = w[14:12]; rd = w[11:7];
    e_en = 0; e_ill = 0;
    if (!iss || w[6:0] != 7'b0001011) return;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a);          ub = longint'(b);
    if (f3 == 0 && mid == 0 && f7 == 0 && rd == 0) m_acc = 0;
    else if (f3 == 0 && mid == 0 && (f7 == 1 || f7 == 2)) begin
      if (rd != 0) begin
        e_en = 1; e_idx = rd;
        e_data = (f7 == 1) ? m_acc[31:0] : m_acc[63:32];
      end
    end else if ((f3 == 1 || f3 == 2) && rd == 0 && f7 <= 1) begin
      p = (f7 == 1) ? longint'(sa * sb) : ua * ub;
      if (f3 == 1) m_acc = {32'h0, p[31:0] + m_acc[31:0]};
      else         m_acc = m_acc + p;
    end else e_ill = 1;
  endtask

  task automatic step(input bit iss, input bit [31:0] w, input bit [31:0] a,
                      input bit [31:0] b, input string tag);
    issue = iss; insn = w; opa = a; opb = b;
    @(posedge clk);
    model(iss, w, a, b);
    @(negedge clk);
    n_cmp++;
    if (wb_en !== e_en || illegal !== e_ill ||
        (e_en && (wb_idx !== e_idx || wb_data !== e_data))) begin
      n_bad++;
      $display("FAIL %s: got en=%0b idx=%0d data=%h ill=%0b, expected en=%0b idx=%0d data=%h ill=%0b",
               tag, wb_en, wb_idx, wb_data, illegal, e_en, e_idx, e_data, e_ill);
    end
  endtask

  task automatic rd_acc(input string tag);
    step(1, mk(7'd1, 0, 3'd0, 5'd7), 0, 0, tag);
    step(1, mk(7'd2, 0, 3'd0, 5'd9), 0, 0, tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [31:0] lf;
    m_acc = 0; e_en = 0; e_ill = 0; e_idx = 0; e_data = 0;
    issue = 0; insn = 0; opa = 0; opb = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: quiet outputs and zero accumulator after reset
    step(0, 0, 0, 0, "R1 idle after reset");
    rd_acc("R1 reset value");
    // R6: unsigned 64-bit accumulate with wrap
    step(1, mk(7'd0, 10'h3ff, 3'd2, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 mac64u");
    rd_acc("R6 first product");
    for (int i = 0; i < 3; i++)
      step(1, mk(7'd0, 10'h021, 3'd2, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6 mac64u wrap");
    rd_acc("R6 wrapped sum");
    // R7: signed extremes and negatives
    step(1, mk(7'd1, 0, 3'd2, 0), 32'h8000_0000, 32'h8000_0000, "R7 mac64s extreme");
    step(1, mk(7'd1, 0, 3'd2, 0), 32'hFFFF_FFFF, 32'd5, "R7 mac64s neg");
    rd_acc("R7 signed sum");
    // R4: 32-bit unsigned clears upper half
    step(1, mk(7'd0, 0, 3'd1, 0), 32'h1234_5678, 32'h0000_0100, "R4 mac32u");
    rd_acc("R4 high word zero");
    step(1, mk(7'd0, 0, 3'd1, 0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 mac32u carry");
    rd_acc("R4 carry dropped");
    // R5: 32-bit signed
    step(1, mk(7'd1, 0, 3'd1, 0), 32'h8000_0000, 32'h8000_0000, "R5 mac32s extreme");
    step(1, mk(7'd1, 0, 3'd1, 0), 32'hFFFF_FFFD, 32'd7, "R5 mac32s neg");
    rd_acc("R5 signed low sum");
    // R2: clear
    step(1, mk(7'd0, 0, 3'd2, 0), 32'hDEAD_BEEF, 32'h7777_0001, "R2 load");
    step(1, mk(7'd0, 0, 3'd0, 0), 0, 0, "R2 clear");
    rd_acc("R2 after clear");
    // R3: read with rd zero
    step(1, mk(7'd0, 0, 3'd2, 0), 32'h0000_1000, 32'h0000_0003, "R3 load");
    step(1, mk(7'd1, 0, 3'd0, 0), 0, 0, "R3 rdlo rd0 no write");
    step(1, mk(7'd2, 0, 3'd0, 0), 0, 0, "R3 rdhi rd0 no write");
    step(1, mk(7'd1, 0, 3'd0, 5'd31), 0, 0, "R3 rdlo rd31");
    // R8: undefined encodings
    step(1, mk(7'd0, 0, 3'd3, 0), 5, 5, "R8 group 3");
    step(1, mk(7'd0, 0, 3'd7, 0), 5, 5, "R8 group 7");
    step(1, mk(7'd3, 0, 3'd0, 5'd4), 5, 5, "R8 mgmt sel 3");
    step(1, mk(7'd0, 0, 3'd0, 5'd4), 5, 5, "R8 clear with rd");
    step(1, mk(7'd2, 0, 3'd1, 0), 5, 5, "R8 mac sel 2");
    step(1, mk(7'd64, 0, 3'd2, 0), 5, 5, "R8 mac sel 64");
    // R9: field constraints
    step(1, mk(7'd0, 0, 3'd2, 5'd1), 5, 5, "R9 mac64 rd nonzero");
    step(1, mk(7'd1, 0, 3'd1, 5'd3), 5, 5, "R9 mac32 rd nonzero");
    step(1, mk(7'd1, 10'h001, 3'd0, 5'd3), 0, 0, "R9 read mid nonzero");
    step(1, mk(7'd0, 10'h200, 3'd0, 0), 0, 0, "R9 clear mid nonzero");
    rd_acc("R8 R9 accumulator held");
    // R10: foreign opcodes
    step(1, mk(7'd0, 0, 3'd0, 0, 7'b0110011), 9, 9, "R10 other opcode clear-like");
    step(1, mk(7'd1, 0, 3'd0, 5'd5, 7'b0101011), 9, 9, "R10 other opcode read-like");
    step(1, mk(7'd0, 0, 3'd2, 0, 7'b0001111), 9, 9, "R10 other opcode mac-like");
    rd_acc("R10 accumulator held");
    // R11: not issued
    step(0, mk(7'd0, 0, 3'd0, 0), 0, 0, "R11 idle clear");
    step(0, mk(7'd1, 0, 3'd0, 5'd2), 0, 0, "R11 idle read");
    step(0, mk(7'd0, 0, 3'd5, 0), 0, 0, "R11 idle bad");
    rd_acc("R11 accumulator held");
    // back-to-back pseudo-random stream, R4 R5 R6 R7 R3 R8
    lf = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      bit [31:0] w, a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf * 32'h9E37_79B9;
      b = lf ^ 32'h5A5A_0F0F;
      unique case (lf[3:0])
        4'd0:        w = mk(7'd0, 0, 3'd0, 0);
        4'd1, 4'd2:  w = mk(7'd1, 0, 3'd0, lf[8:4]);
        4'd3, 4'd4:  w = mk(7'd2, 0, 3'd0, lf[8:4]);
        4'd5, 4'd6:  w = mk({6'd0, lf[9]}, lf[19:10], 3'd1, 0);
        4'd7, 4'd8, 4'd9: w = mk({6'd0, lf[9]}, lf[19:10], 3'd2, 0);
        4'd10:       w = mk(lf[31:25], lf[24:15], lf[14:12], lf[11:7]);
        default:     w = mk(7'd1, 0, 3'd0, 5'd1 | lf[8:4]);
      endcase
      step(1, w, a, b, "R3 R4 R5 R6 R7 R8 random stream");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule